// File: doc/BRIEF.md
# CAM host-port cycle steering front end

This block sits between a 16-bit host bus and the internals of a content-addressable memory device. On every clock in which the active-low enable is low, it samples a command/data select and a write strobe. It classifies the bus cycle as a command write, command read, data write or data read, and then routes that cycle to one internal register or to the memory-array port.

Command cycles normally go to fixed targets. A command write loads the instruction decoder, and a command read returns the status word. Two one-shot mechanisms can divert the next command cycle:
- an address-field flag in the instruction just loaded sends the next command write to the address register;
- a redirect instruction sends the next command cycle to a named register.

Data cycles go to a persistent destination or come from a persistent source. These hold until a select instruction changes them.

The device-select register is compared with the page-address register. When they differ the device ignores the host. The one exception is a device-select value of all ones, which leaves the device write-only. The array match logic, the priority encoder and next-free-address generation are outside the block. They reach it only as stub inputs and a simple array read/write port.

Top module: `cam_host_port`

## Requirements
- R1: A clock with `en_n` high is not a bus cycle. No register or one-shot state changes, and `data_oe` is 0 in the following clock.
- R2: A selected command write (`cmd_n`=0, `wr_n`=0) with no one-shot pending is decoded as an instruction.
  - Bits 15:12 give the class: 1 redirect, 2 select source, 3 select destination, any other value has no effect.
  - Bit 11 is the address-field flag.
  - Bits 3:0 give the resource code.
- R3: After an instruction with bit 11 set, the next selected cycle, if it is a command write, loads the address register. Any selected cycle consumes the flag.
- R4: After a redirect instruction, only the next selected cycle uses the named target. Target codes are 0 address, 1 control, 2 page address, 3 segment control, 4 device select, 5 next-free address, 6 source readback, 7 destination readback. Any selected cycle, data cycles included, consumes the redirect.
- R5: A redirected command read returns the named register, or `nfa_in` for code 5. A redirected command write to code 5 changes nothing.
- R6: A command read with no redirect returns `status_in[15:0]`.
  - If the previous selected cycle was such a low-half read, the read returns `status_in[31:16]` instead.
  - Any other selected cycle in between makes the next read return the low half again.
- R7: A selected data write goes to the persistent destination. Destination codes are 0 comparand, 1 mask 1, 2 mask 2, 3 array at address register, 4 array at `nfa_in`, 5 array at `hit_in`. After reset the destination is the comparand.
- R8: A selected data read comes from the persistent source. Source codes are as for the destination, except that code 4 is not valid. After reset the source is the comparand, and all registers reset to 0.
- R9: An array write drives `arr_we` combinationally in the same clock, with `arr_wr_addr` taken from the selected address and `arr_wdata` equal to `data_in`. An array read drives `arr_re` and `arr_rd_addr`, and returns `arr_rdata`.
- R10: A command read after redirect code 6 (source) or 7 (destination) returns the full instruction word that last set that persistent resource.
- R11: When device select differs from page address and is not all ones, every cycle is ignored and `data_oe` stays 0. The exceptions are a redirect instruction with resource code 4 and the device-select load that follows it.
- R12: When device select is all ones and differs from page address, writes take effect and reads are ignored, with `data_oe` 0.
- R13: Read data is registered. For an accepted read, `data_out` and `data_oe`=1 appear in the next clock. At all other times `data_oe` is 0 and `data_out` is 0.
- R14: Select instructions with an invalid resource code, redirect instructions with a target above 7, and instructions of an unknown class change no steering state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low cycle enable |
| cmd_n | input | 1 | Low for command cycle, high for data cycle |
| wr_n | input | 1 | Low for write, high for read |
| data_in | input | DATA_W | Host write data |
| data_out | output | DATA_W | Registered read data |
| data_oe | output | 1 | Bus output enable (tri-state control) |
| status_in | input | 2*DATA_W | Status word from the device core |
| nfa_in | input | DATA_W | Next-free address from the core |
| hit_in | input | DATA_W | Highest-priority match address from the core |
| arr_we | output | 1 | Array write strobe |
| arr_wr_addr | output | DATA_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| arr_re | output | 1 | Array read strobe |
| arr_rd_addr | output | DATA_W | Array read address |
| arr_rdata | input | DATA_W | Array read data |

## Verification
The assertions check the following on every cycle:
- the output enable only ever follows an enabled read;
- the bus is quiet when the output enable is low;
- idle clocks and ignored deselected cycles leave the page, device-select and status-split state untouched;
- a redirect lapses after a data cycle;
- the status high half is armed only by a low-half read.

The steering contents can only be shown by the bench's scenarios, which run a behavioural model on every clock. These contents include:
- which register a redirected or address-flagged write actually reached;
- the persistent selections and their readback words;
- the array addresses;
- the write-only window and recovery from deselection.

// File: rtl/cam_hp_pkg.sv
package cam_hp_pkg;

  typedef enum logic [1:0] {
    CYC_CW = 2'd0,
    CYC_CR = 2'd1,
    CYC_DW = 2'd2,
    CYC_DR = 2'd3
  } cyc_e;

  localparam int OP_CLS_LSB = 12;
  localparam int OP_AF_BIT  = 11;

  localparam logic [3:0] CLS_REDIR = 4'h1;
  localparam logic [3:0] CLS_PSRC  = 4'h2;
  localparam logic [3:0] CLS_PDST  = 4'h3;

  // redirect targets
  localparam logic [3:0] TGT_ADDR = 4'd0;
  localparam logic [3:0] TGT_CTRL = 4'd1;
  localparam logic [3:0] TGT_PAGE = 4'd2;
  localparam logic [3:0] TGT_SEG  = 4'd3;
  localparam logic [3:0] TGT_DSEL = 4'd4;
  localparam logic [3:0] TGT_NFA  = 4'd5;
  localparam logic [3:0] TGT_PSRB = 4'd6;
  localparam logic [3:0] TGT_PDRB = 4'd7;

  // persistent resources
  localparam logic [3:0] RES_CMP      = 4'd0;
  localparam logic [3:0] RES_MSK1     = 4'd1;
  localparam logic [3:0] RES_MSK2     = 4'd2;
  localparam logic [3:0] RES_ARR_ADDR = 4'd3;
  localparam logic [3:0] RES_ARR_NFA  = 4'd4;
  localparam logic [3:0] RES_ARR_HIT  = 4'd5;

  function automatic cyc_e cyc_of(input logic cmd_n, input logic wr_n);
    return cyc_e'({cmd_n, wr_n});
  endfunction

  function automatic logic [3:0] op_class(input logic [15:0] w);
    return w[OP_CLS_LSB +: 4];
  endfunction

  function automatic logic [3:0] op_code(input logic [15:0] w);
    return w[3:0];
  endfunction

  function automatic logic dest_ok(input logic [3:0] c);
    return c <= RES_ARR_HIT;
  endfunction

  function automatic logic src_ok(input logic [3:0] c);
    return (c <= RES_ARR_HIT) && (c != RES_ARR_NFA);
  endfunction

  function automatic logic res_is_array(input logic [3:0] c);
    return (c == RES_ARR_ADDR) || (c == RES_ARR_NFA) || (c == RES_ARR_HIT);
  endfunction

  function automatic logic is_dsel_redirect(input logic [15:0] w);
    return (op_class(w) == CLS_REDIR) && (op_code(w) == TGT_DSEL);
  endfunction

endpackage

// File: rtl/cam_hp_select.sv
module cam_hp_select
  import cam_hp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              en_n,
  input  logic              cmd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] ds_q,
  input  logic [DATA_W-1:0] page_q,
  input  logic              redir_pend,
  input  logic [3:0]        redir_tgt,
  input  logic              af_pend,
  output logic              sel_rd,
  output logic              sel_wr,
  output logic              acc_cw,
  output logic              acc_cr,
  output logic              acc_dw,
  output logic              acc_dr,
  output logic              acc_any
);

  cyc_e cyc;
  logic live;
  logic ds_cmd;

  always_comb begin
    cyc    = cyc_of(cmd_n, wr_n);
    live   = !en_n;
    sel_rd = (ds_q == page_q);
    sel_wr = sel_rd || (&ds_q);
    // path that stays open while deselected: arm or complete a device-select load
    if (redir_pend) ds_cmd = (redir_tgt == TGT_DSEL);
    else            ds_cmd = !af_pend && is_dsel_redirect(din[15:0]);
    acc_cw  = live && (cyc == CYC_CW) && (sel_wr || ds_cmd);
    acc_cr  = live && (cyc == CYC_CR) && sel_rd;
    acc_dw  = live && (cyc == CYC_DW) && sel_wr;
    acc_dr  = live && (cyc == CYC_DR) && sel_rd;
    acc_any = acc_cw || acc_cr || acc_dw || acc_dr;
  end

endmodule

// File: rtl/cam_hp_cmd.sv
module cam_hp_cmd
  import cam_hp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_cw,
  input  logic              acc_cr,
  input  logic              acc_any,
  input  logic [DATA_W-1:0] din,
  input  logic [STAT_W-1:0] status_in,
  input  logic [DATA_W-1:0] nfa_in,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] ds_q,
  output logic [DATA_W-1:0] page_q,
  output logic              redir_pend,
  output logic [3:0]        redir_tgt,
  output logic              af_pend,
  output logic              stat_hi_pend,
  output logic [3:0]        ps_code,
  output logic [3:0]        pd_code,
  output logic [DATA_W-1:0] cr_data
);

  localparam int HALF_W = STAT_W / 2;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] seg_q;
  logic [DATA_W-1:0] ps_word;
  logic [DATA_W-1:0] pd_word;

  logic       new_ins;
  logic [3:0] ins_cls;
  logic [3:0] ins_code;
  logic       ins_redir;
  logic       ins_psrc;
  logic       ins_pdst;

  always_comb begin
    new_ins   = acc_cw && !redir_pend && !af_pend;
    ins_cls   = op_class(din[15:0]);
    ins_code  = op_code(din[15:0]);
    ins_redir = new_ins && (ins_cls == CLS_REDIR) && (ins_code <= TGT_PDRB);
    ins_psrc  = new_ins && (ins_cls == CLS_PSRC) && src_ok(ins_code);
    ins_pdst  = new_ins && (ins_cls == CLS_PDST) && dest_ok(ins_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q       <= '0;
      ctrl_q       <= '0;
      page_q       <= '0;
      seg_q        <= '0;
      ds_q         <= '0;
      redir_pend   <= 1'b0;
      redir_tgt    <= TGT_ADDR;
      af_pend      <= 1'b0;
      stat_hi_pend <= 1'b0;
      ps_code      <= RES_CMP;
      pd_code      <= RES_CMP;
      ps_word      <= '0;
      pd_word      <= '0;
    end else if (acc_any) begin
      redir_pend   <= ins_redir;
      af_pend      <= new_ins && din[OP_AF_BIT];
      stat_hi_pend <= acc_cr && !redir_pend && !stat_hi_pend;
      if (ins_redir) redir_tgt <= ins_code;
      if (acc_cw && redir_pend) begin
        case (redir_tgt)
          TGT_ADDR: addr_q <= din;
          TGT_CTRL: ctrl_q <= din;
          TGT_PAGE: page_q <= din;
          TGT_SEG:  seg_q  <= din;
          TGT_DSEL: ds_q   <= din;
          default:  ;
        endcase
      end else if (acc_cw && af_pend) begin
        addr_q <= din;
      end
      if (ins_psrc) begin
        ps_code <= ins_code;
        ps_word <= din;
      end
      if (ins_pdst) begin
        pd_code <= ins_code;
        pd_word <= din;
      end
    end
  end

  always_comb begin
    cr_data = '0;
    if (redir_pend) begin
      case (redir_tgt)
        TGT_ADDR: cr_data = addr_q;
        TGT_CTRL: cr_data = ctrl_q;
        TGT_PAGE: cr_data = page_q;
        TGT_SEG:  cr_data = seg_q;
        TGT_DSEL: cr_data = ds_q;
        TGT_NFA:  cr_data = nfa_in;
        TGT_PSRB: cr_data = ps_word;
        TGT_PDRB: cr_data = pd_word;
        default:  cr_data = '0;
      endcase
    end else if (stat_hi_pend) begin
      cr_data = DATA_W'(status_in[STAT_W-1:HALF_W]);
    end else begin
      cr_data = DATA_W'(status_in[HALF_W-1:0]);
    end
  end

endmodule

// File: rtl/cam_hp_data.sv
module cam_hp_data
  import cam_hp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_dw,
  input  logic              acc_dr,
  input  logic [DATA_W-1:0] din,
  input  logic [3:0]        ps_code,
  input  logic [3:0]        pd_code,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] nfa_in,
  input  logic [DATA_W-1:0] hit_in,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_we,
  output logic [DATA_W-1:0] arr_wr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_re,
  output logic [DATA_W-1:0] arr_rd_addr,
  output logic [DATA_W-1:0] dr_data
);

  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] msk1_q;
  logic [DATA_W-1:0] msk2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      msk1_q <= '0;
      msk2_q <= '0;
    end else if (acc_dw) begin
      case (pd_code)
        RES_CMP:  cmp_q  <= din;
        RES_MSK1: msk1_q <= din;
        RES_MSK2: msk2_q <= din;
        default:  ;
      endcase
    end
  end

  always_comb begin
    arr_we    = acc_dw && res_is_array(pd_code);
    arr_wdata = din;
    case (pd_code)
      RES_ARR_NFA: arr_wr_addr = nfa_in;
      RES_ARR_HIT: arr_wr_addr = hit_in;
      default:     arr_wr_addr = addr_q;
    endcase
    arr_re      = acc_dr && res_is_array(ps_code);
    arr_rd_addr = (ps_code == RES_ARR_HIT) ? hit_in : addr_q;
    case (ps_code)
      RES_CMP:      dr_data = cmp_q;
      RES_MSK1:     dr_data = msk1_q;
      RES_MSK2:     dr_data = msk2_q;
      RES_ARR_ADDR: dr_data = arr_rdata;
      RES_ARR_HIT:  dr_data = arr_rdata;
      default:      dr_data = '0;
    endcase
  end

endmodule

// File: rtl/cam_host_port.sv
module cam_host_port
  import cam_hp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_n,
  input  logic                cmd_n,
  input  logic                wr_n,
  input  logic [DATA_W-1:0]   data_in,
  output logic [DATA_W-1:0]   data_out,
  output logic                data_oe,
  input  logic [2*DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0]   nfa_in,
  input  logic [DATA_W-1:0]   hit_in,
  output logic                arr_we,
  output logic [DATA_W-1:0]   arr_wr_addr,
  output logic [DATA_W-1:0]   arr_wdata,
  output logic                arr_re,
  output logic [DATA_W-1:0]   arr_rd_addr,
  input  logic [DATA_W-1:0]   arr_rdata
);

  localparam int STAT_W = 2 * DATA_W;

  logic              sel_rd, sel_wr;
  logic              acc_cw, acc_cr, acc_dw, acc_dr, acc_any;
  logic [DATA_W-1:0] addr_q, ds_q, page_q;
  logic              redir_pend, af_pend, stat_hi_pend;
  logic [3:0]        redir_tgt, ps_code, pd_code;
  logic [DATA_W-1:0] cr_data, dr_data;

  cam_hp_select #(.DATA_W(DATA_W)) u_sel (
    .en_n       (en_n),
    .cmd_n      (cmd_n),
    .wr_n       (wr_n),
    .din        (data_in),
    .ds_q       (ds_q),
    .page_q     (page_q),
    .redir_pend (redir_pend),
    .redir_tgt  (redir_tgt),
    .af_pend    (af_pend),
    .sel_rd     (sel_rd),
    .sel_wr     (sel_wr),
    .acc_cw     (acc_cw),
    .acc_cr     (acc_cr),
    .acc_dw     (acc_dw),
    .acc_dr     (acc_dr),
    .acc_any    (acc_any)
  );

  cam_hp_cmd #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_cw       (acc_cw),
    .acc_cr       (acc_cr),
    .acc_any      (acc_any),
    .din          (data_in),
    .status_in    (status_in),
    .nfa_in       (nfa_in),
    .addr_q       (addr_q),
    .ds_q         (ds_q),
    .page_q       (page_q),
    .redir_pend   (redir_pend),
    .redir_tgt    (redir_tgt),
    .af_pend      (af_pend),
    .stat_hi_pend (stat_hi_pend),
    .ps_code      (ps_code),
    .pd_code      (pd_code),
    .cr_data      (cr_data)
  );

  cam_hp_data #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_dw      (acc_dw),
    .acc_dr      (acc_dr),
    .din         (data_in),
    .ps_code     (ps_code),
    .pd_code     (pd_code),
    .addr_q      (addr_q),
    .nfa_in      (nfa_in),
    .hit_in      (hit_in),
    .arr_rdata   (arr_rdata),
    .arr_we      (arr_we),
    .arr_wr_addr (arr_wr_addr),
    .arr_wdata   (arr_wdata),
    .arr_re      (arr_re),
    .arr_rd_addr (arr_rd_addr),
    .dr_data     (dr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe <= acc_cr || acc_dr;
      if (acc_cr)      data_out <= cr_data;
      else if (acc_dr) data_out <= dr_data;
      else             data_out <= '0;
    end
  end

endmodule

// File: rtl/cam_host_port_chk.sv
module cam_host_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic              wr_n,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic              arr_we,
  input logic              cmd_n,
  input logic              sel_rd,
  input logic              sel_wr,
  input logic              acc_cw,
  input logic              acc_cr,
  input logic              acc_dw,
  input logic              acc_dr,
  input logic              acc_any,
  input logic              redir_pend,
  input logic              stat_hi_pend,
  input logic [DATA_W-1:0] page_q,
  input logic [DATA_W-1:0] ds_q
);

  // R13
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(!en_n && wr_n && sel_rd));

  // R13
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  // R1
  idle_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !data_oe);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> ($stable(page_q) && $stable(ds_q) && $stable(stat_hi_pend) && $stable(redir_pend)));

  // R11
  desel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !sel_wr && !acc_cw) |=> ($stable(page_q) && $stable(ds_q) && $stable(stat_hi_pend) && !data_oe));

  // R12
  write_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && wr_n && sel_wr && !sel_rd) |=> !data_oe);

  // R9
  arr_we_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (!en_n && !wr_n && cmd_n && acc_dw));

  // R4
  redir_lapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_pend && acc_any && !acc_cw) |=> !redir_pend);

  // R6
  stat_hi_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_hi_pend) |-> $past(acc_cr && !redir_pend));

  // R13
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({acc_cw, acc_cr, acc_dw, acc_dr}) <= 1);

endmodule

bind cam_host_port cam_host_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cam_host_port_bench.sv
`timescale 1ns/1ps
module cam_host_port_bench;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_n = 1'b1, cmd_n = 1'b1, wr_n = 1'b1;
  logic [W-1:0]  data_in = '0;
  logic [W-1:0]  data_out;
  logic          data_oe;
  logic [2*W-1:0] status_in = 32'hA1B2_C3D4;
  logic [W-1:0]  nfa_in = 16'h0123;
  logic [W-1:0]  hit_in = 16'h0456;
  logic          arr_we, arr_re;
  logic [W-1:0]  arr_wr_addr, arr_wdata, arr_rd_addr, arr_rdata;

  assign arr_rdata = arr_rd_addr ^ 16'hF00F;

  always #2 clk = ~clk;

  cam_host_port #(.DATA_W(W)) u_cam_host_port (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .cmd_n(cmd_n), .wr_n(wr_n),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .status_in(status_in), .nfa_in(nfa_in), .hit_in(hit_in),
    .arr_we(arr_we), .arr_wr_addr(arr_wr_addr), .arr_wdata(arr_wdata),
    .arr_re(arr_re), .arr_rd_addr(arr_rd_addr), .arr_rdata(arr_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_addr = 0, m_ctrl = 0, m_page = 0, m_seg = 0, m_ds = 0;
  logic [15:0] m_psw = 0, m_pdw = 0, m_cmp = 0, m_m1 = 0, m_m2 = 0;
  logic [3:0]  m_rt = 0, m_ps = 0, m_pd = 0;
  bit          m_rp = 0, m_af = 0, m_sh = 0;
  bit          exp_oe = 0;
  logic [15:0] exp_do = 0;
  bit          e_we, e_re;
  logic [15:0] e_wa, e_wd, e_ra;
  bit          obs_oe;
  logic [15:0] obs_do;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit en, input bit c, input bit w, input logic [15:0] d);
    bit selr, selw, dscmd, acw, acr, adw, adr, newi;
    logic [3:0] cls, cd;
    logic [15:0] rv;
    e_we = 0; e_re = 0; e_wa = 0; e_wd = 0; e_ra = 0;
    exp_oe = 0; exp_do = 0;
    selr = (m_ds == m_page);
    selw = selr || (m_ds == 16'hFFFF);
    cls = d[15:12]; cd = d[3:0];
    if (m_rp) dscmd = (m_rt == 4);
    else      dscmd = !m_af && cls == 1 && cd == 4;
    acw = !en && !c && !w && (selw || dscmd);
    acr = !en && !c && w && selr;
    adw = !en && c && !w && selw;
    adr = !en && c && w && selr;
    if (!(acw || acr || adw || adr)) return;
    rv = 0;
    if (acr) begin
      if (m_rp) begin
        case (m_rt)
          0: rv = m_addr; 1: rv = m_ctrl; 2: rv = m_page; 3: rv = m_seg;
          4: rv = m_ds; 5: rv = nfa_in; 6: rv = m_psw; 7: rv = m_pdw;
          default: rv = 0;
        endcase
      end else if (m_sh) rv = status_in[31:16];
      else rv = status_in[15:0];
      exp_oe = 1; exp_do = rv;
    end
    if (adr) begin
      if (m_ps == 3) begin e_re = 1; e_ra = m_addr; rv = m_addr ^ 16'hF00F; end
      else if (m_ps == 5) begin e_re = 1; e_ra = hit_in; rv = hit_in ^ 16'hF00F; end
      else if (m_ps == 1) rv = m_m1;
      else if (m_ps == 2) rv = m_m2;
      else rv = m_cmp;
      exp_oe = 1; exp_do = rv;
    end
    if (adw) begin
      case (m_pd)
        0: m_cmp = d; 1: m_m1 = d; 2: m_m2 = d;
        3: begin e_we = 1; e_wa = m_addr; e_wd = d; end
        4: begin e_we = 1; e_wa = nfa_in; e_wd = d; end
        5: begin e_we = 1; e_wa = hit_in; e_wd = d; end
        default: ;
      endcase
    end
    newi = acw && !m_rp && !m_af;
    if (acw && m_rp) begin
      case (m_rt)
        0: m_addr = d; 1: m_ctrl = d; 2: m_page = d; 3: m_seg = d; 4: m_ds = d;
        default: ;
      endcase
    end else if (acw && m_af) m_addr = d;
    m_sh = acr && !m_rp && !m_sh;
    m_rp = newi && cls == 1 && cd <= 7;
    if (m_rp) m_rt = cd;
    m_af = newi && d[11];
    if (newi && cls == 2 && cd <= 5 && cd != 4) begin m_ps = cd; m_psw = d; end
    if (newi && cls == 3 && cd <= 5) begin m_pd = cd; m_pdw = d; end
  endtask

  task automatic do_cyc(input bit en, input bit c, input bit w, input logic [15:0] d);
    @(negedge clk);
    obs_oe = data_oe; obs_do = data_out;
    chk(obs_oe == exp_oe, "R13 model data_oe", {31'b0, obs_oe}, {31'b0, exp_oe});
    chk(obs_do == exp_do, "R13 model data_out", {16'b0, obs_do}, {16'b0, exp_do});
    en_n = en; cmd_n = c; wr_n = w; data_in = d;
    #1;
    model(en, c, w, d);
    chk(arr_we == e_we, "R9 model arr_we", {31'b0, arr_we}, {31'b0, e_we});
    if (e_we) begin
      chk(arr_wr_addr == e_wa, "R9 model arr_wr_addr", {16'b0, arr_wr_addr}, {16'b0, e_wa});
      chk(arr_wdata == e_wd, "R9 model arr_wdata", {16'b0, arr_wdata}, {16'b0, e_wd});
    end
    chk(arr_re == e_re, "R9 model arr_re", {31'b0, arr_re}, {31'b0, e_re});
    if (e_re) chk(arr_rd_addr == e_ra, "R9 model arr_rd_addr", {16'b0, arr_rd_addr}, {16'b0, e_ra});
  endtask

  task automatic cw(input logic [15:0] d); do_cyc(0, 0, 0, d); endtask
  task automatic cr(); do_cyc(0, 0, 1, 16'h0); endtask
  task automatic dw(input logic [15:0] d); do_cyc(0, 1, 0, d); endtask
  task automatic dr(); do_cyc(0, 1, 1, 16'h0); endtask
  task automatic idle(); do_cyc(1, 1, 1, 16'h0); endtask

  // read result appears in the clock after the read cycle
  task automatic want(input string tag, input bit oe, input logic [15:0] v);
    idle();
    chk(obs_oe == oe, tag, {31'b0, obs_oe}, {31'b0, oe});
    if (oe) chk(obs_do == v, tag, {16'b0, obs_do}, {16'b0, v});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R13 reset state
    chk(data_oe == 0, "R13 reset oe", {31'b0, data_oe}, 0);
    chk(data_out == 0, "R13 reset data", {16'b0, data_out}, 0);

    dr();           want("R8 reset source comparand", 1, 16'h0000);
    dw(16'h1234);
    dr();           want("R7 write to comparand", 1, 16'h1234);

    cr();           want("R6 status low", 1, 16'hC3D4);
    cr();           want("R6 status high", 1, 16'hA1B2);
    cr();           want("R6 status low again", 1, 16'hC3D4);
    dr();           want("R6 other cycle", 1, 16'h1234);
    cr();           want("R6 restart low", 1, 16'hC3D4);

    cw(16'h1001); cw(16'hBEEF);
    cw(16'h1001); cr(); want("R5 redirect ctrl read", 1, 16'hBEEF);
    cw(16'h1001); cw(16'h1111); cw(16'h0777);
    cw(16'h1001); cr(); want("R4 redirect lapses", 1, 16'h1111);
    cw(16'h1001); dr(); want("R4 data read consumes", 1, 16'h1234);
    cw(16'h0222);
    cw(16'h1001); cr(); want("R4 ctrl kept", 1, 16'h1111);

    cw(16'h0800); cw(16'h00AA);
    cw(16'h1000); cr(); want("R3 address flag load", 1, 16'h00AA);
    cw(16'h0800); dr(); cw(16'h00BB);
    cw(16'h1000); cr(); want("R3 flag one cycle only", 1, 16'h00AA);

    cw(16'h1005); cr(); want("R5 nfa read", 1, 16'h0123);
    cw(16'h1005); cw(16'h9999);
    cw(16'h1000); cr(); want("R5 nfa write ignored", 1, 16'h00AA);
    cw(16'h1003); cw(16'h5A5A);
    cw(16'h1003); cr(); want("R5 segment read", 1, 16'h5A5A);

    cw(16'h3001); dw(16'h00F0);
    cw(16'h2001); dr(); want("R2 instruction selects mask1 source", 1, 16'h00F0);
    cw(16'h1007); cr(); want("R10 destination readback", 1, 16'h3001);
    cw(16'h1006); cr(); want("R10 source readback", 1, 16'h2001);

    cw(16'h3003); dw(16'h5555);
    chk(arr_we && arr_wr_addr == 16'h00AA, "R9 array write at address", {16'b0, arr_wr_addr}, 32'h00AA);
    cw(16'h3004); dw(16'h6666);
    chk(arr_we && arr_wr_addr == 16'h0123, "R7 array write at nfa", {16'b0, arr_wr_addr}, 32'h0123);
    cw(16'h3005); dw(16'h7777);
    chk(arr_we && arr_wr_addr == 16'h0456, "R7 array write at hit", {16'b0, arr_wr_addr}, 32'h0456);
    cw(16'h2005); dr(); want("R9 array read at hit", 1, 16'hF459);
    cw(16'h2004); dr(); want("R8 nfa source rejected", 1, 16'hF459);
    cw(16'h2003); dr(); want("R9 array read at address", 1, 16'hF0A5);

    cw(16'h300F);
    cw(16'h1007); cr(); want("R14 bad destination code", 1, 16'h3005);
    cw(16'h5003);
    cw(16'h1007); cr(); want("R14 unknown class", 1, 16'h3005);
    cw(16'h100E); cw(16'h4444);
    cw(16'h1001); cr(); want("R14 bad redirect target", 1, 16'h1111);

    cw(16'h3000); cw(16'h2000);
    dr(); want("R7 back to comparand", 1, 16'h1234);

    cw(16'h1002); cw(16'h0001);
    cr(); want("R11 deselected command read", 0, 16'h0);
    dr(); want("R11 deselected data read", 0, 16'h0);
    dw(16'h7777); cw(16'h2001);
    cw(16'h1004); cw(16'h0001);
    dr(); want("R11 reselected, nothing changed", 1, 16'h1234);

    cw(16'h1004); cw(16'hFFFF);
    dw(16'h4321);
    dr(); want("R12 write-only read blocked", 0, 16'h0);
    cr(); want("R12 write-only command read blocked", 0, 16'h0);
    cw(16'h1004); cw(16'h0001);
    dr(); want("R12 write took effect", 1, 16'h4321);

    do_cyc(1, 1, 0, 16'hDEAD);
    do_cyc(1, 0, 0, 16'h1002);
    cw(16'h0009);
    dr(); want("R1 idle clocks ignored", 1, 16'h4321);

    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule